// File: doc/BRIEF.md
# Prescaled Reload Interval Timer

This block raises a periodic interrupt request. A 16-bit down-counter steps once every several clock cycles, and an 8-bit scale value sets that step rate. When a step finds the counter at zero, the counter is loaded again from a 16-bit period value and a one-cycle interrupt request goes out. With period P and scale S, the interrupt repeats every (P+1)*(S+1) enabled cycles.

Software programs the block through a single-cycle write port with a 2-bit register select. The port reaches the scale, period, count and control registers. The current count is always visible on an output. An enable bit starts and stops the timer without losing its state.

Top module: `interval_tmr`

## Requirements
- R1: After reset the count is 0, the scale and period are 0, the timer is disabled and irq_o is low.
- R2: A write with wr_en_i high stores wr_data_i in the register picked by addr_i: 0 selects control (bit 0 is the enable), 1 selects scale (bits 7:0), 2 selects period, and 3 selects count.
- R3: While enabled, the counter takes one step every scale+1 enabled cycles, so a scale of 0 gives a step on every enabled cycle.
- R4: A step on a nonzero count decreases the count by exactly one.
- R5: A step on a count of zero loads the count from the period register.
- R6: irq_o is high for exactly the cycles in which count_o first shows a value that a step-at-zero reloaded, and is low otherwise.
- R7: A count write in the same cycle as a step wins over that step. The written value appears, and no interrupt comes from that cycle.
- R8: A scale write clears the prescaler's divide counter, and the counter does not step in that cycle.
- R9: While the enable bit is low, the count and the divide counter hold their values and irq_o stays low. Count writes still take effect.
- R10: count_o shows the current count register in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench aims count writes at cycles where a step or a reload also falls due. A design with the wrong priority would show a decremented or reloaded value, or a stray interrupt, in place of the written value. It also writes the scale register partway through a divide interval. A design that kept the old divide phase would step too early or too late. It runs with a period and scale of zero, where an interrupt is due on every cycle, which a design that forced idle cycles between pulses would miss. It also checks that disabling freezes the count exactly and that an exact number of interrupts falls in a fixed window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SCALE  = 2'd1,
    REG_PERIOD = 2'd2,
    REG_COUNT  = 2'd3
  } tmr_reg_e;
  localparam int unsigned CTRL_EN_BIT = 0;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             en_o,
  output logic [SCL_W-1:0] scale_o,
  output logic [CNT_W-1:0] period_o,
  output logic             scale_wr_o,
  output logic             count_wr_o,
  output logic [CNT_W-1:0] count_wdata_o
);
  logic             en_q;
  logic [SCL_W-1:0] scale_q;
  logic [CNT_W-1:0] period_q;
  tmr_reg_e         sel;

  assign sel = tmr_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      scale_q  <= '0;
      period_q <= '0;
    end else if (wr_en_i) begin
      case (sel)
        REG_CTRL:   en_q     <= wr_data_i[CTRL_EN_BIT];
        REG_SCALE:  scale_q  <= wr_data_i[SCL_W-1:0];
        REG_PERIOD: period_q <= wr_data_i;
        default:    ;
      endcase
    end
  end

  assign en_o          = en_q;
  assign scale_o       = scale_q;
  assign period_o      = period_q;
  assign scale_wr_o    = wr_en_i && (sel == REG_SCALE);
  assign count_wr_o    = wr_en_i && (sel == REG_COUNT);
  assign count_wdata_o = wr_data_i;

  p_period_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == REG_PERIOD) |=> period_q == $past(wr_data_i));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SCL_W-1:0] scale_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [SCL_W-1:0] div_q;

  // a scale write suppresses the step of its own cycle
  assign tick_o = en_i && !clr_i && (div_q == scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (en_i)   div_q <= tick_o ? '0 : div_q + 1'b1;
  end

  p_div_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= scale_i);
  p_scale_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0);
  p_div_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(div_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             irq_q;
  logic             at_zero;

  assign at_zero = (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= tick_i && at_zero && !load_i;
      if (load_i)       count_q <= load_val_i;
      else if (tick_i)  count_q <= at_zero ? period_i : count_q - 1'b1;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  p_write_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i)) && !irq_q);
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && count_q == '0) |=> count_q == $past(period_i));
  p_irq_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(count_q) == '0);
endmodule

// File: rtl/interval_tmr.sv
module interval_tmr
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic             en;
  logic [SCL_W-1:0] scale;
  logic [CNT_W-1:0] period;
  logic             scale_wr;
  logic             count_wr;
  logic [CNT_W-1:0] count_wdata;
  logic             tick;

  tmr_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i,
    .en_o(en), .scale_o(scale), .period_o(period),
    .scale_wr_o(scale_wr), .count_wr_o(count_wr), .count_wdata_o(count_wdata)
  );

  tmr_prescaler #(.SCL_W(SCL_W)) u_presc (
    .clk_i, .rst_ni, .en_i(en), .scale_i(scale), .clr_i(scale_wr), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(count_wr), .load_val_i(count_wdata),
    .period_i(period), .count_o, .irq_o
  );

  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !count_wr) |=> $stable(count_o) && !irq_o);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0) && !irq_o);
endmodule

// File: tb/interval_tmr_tb.sv
module interval_tmr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  typedef struct packed { logic [15:0] cnt; logic irq; } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] count_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  exp_t q[$];

  // reference state derived from the requirements
  logic        m_en = 0;
  logic [7:0]  m_scale = 0, m_div = 0;
  logic [15:0] m_period = 0, m_cnt = 0;

  interval_tmr u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en <= 0; m_scale <= 0; m_div <= 0; m_period <= 0; m_cnt <= 0;
      q.delete();
    end else begin
      logic sw, cw, step, irq;
      logic [15:0] nc;
      sw   = wr_en_i && addr_i == 2'd1;
      cw   = wr_en_i && addr_i == 2'd3;
      step = m_en && !sw && m_div == m_scale;            // R3, R8
      irq  = step && m_cnt == 0 && !cw;                  // R6, R7
      nc   = cw ? wr_data_i : step ? (m_cnt == 0 ? m_period : m_cnt - 16'd1) : m_cnt; // R4 R5
      if (sw) m_div <= 0; else if (m_en) m_div <= step ? 8'd0 : m_div + 8'd1;
      m_cnt <= nc;
      if (wr_en_i && addr_i == 2'd0) m_en <= wr_data_i[0]; // R2
      if (sw) m_scale <= wr_data_i[7:0];
      if (wr_en_i && addr_i == 2'd2) m_period <= wr_data_i;
      q.push_back('{cnt: nc, irq: irq});
    end
  end

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: R10 count readback is compared on every cycle
  always @(negedge clk_i) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(phase, {count_o, irq_o}, {e.cnt, e.irq});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int irqs;
    #(CLK_PERIOD * 2 + 1);
    check("R1", {count_o, irq_o}, 17'h0);
    rst_ni = 1'b1;
    idle(3);
    check("R1", {count_o, irq_o}, 17'h0);

    phase = "R4";
    wr(2'd2, 16'd3); wr(2'd1, 16'd0); wr(2'd3, 16'd2); wr(2'd0, 16'd1);
    phase = "R5"; idle(20);
    phase = "R3"; wr(2'd1, 16'd2); idle(40);
    phase = "R8";
    for (int i = 0; i < 6; i++) begin wr(2'd1, 16'(i % 3)); idle(i + 1); end
    phase = "R7";
    for (int i = 0; i < 12; i++) begin wr(2'd3, 16'(i % 2)); idle(i % 4); end
    phase = "R9";
    wr(2'd0, 16'd0); idle(10); wr(2'd3, 16'h1234); idle(10);
    phase = "R2"; wr(2'd2, 16'h0005); wr(2'd0, 16'hFFFE); idle(8);
    phase = "R6";
    wr(2'd2, 16'd0); wr(2'd1, 16'd0); wr(2'd3, 16'd0); wr(2'd0, 16'd1); idle(10);
    wr(2'd0, 16'd0);

    // R6: scale 1, period 4, from count 0 -> one pulse every 10 cycles
    phase = "R10";
    wr(2'd1, 16'd1); wr(2'd2, 16'd4); wr(2'd3, 16'd0);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = 2'd0; wr_data_i = 16'd1;
    @(negedge clk_i); wr_en_i = 1'b0;
    irqs = 0;
    for (int i = 0; i < 100; i++) begin
      if (irq_o) irqs++;
      @(negedge clk_i);
    end
    check("R6 pulse tally", 17'(irqs), 17'd10);
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule